// File: doc/BRIEF.md
# Linked-List Transmit Descriptor Engine

This block is one transmit channel of a serial DMA. Software places a chain of four-word descriptors in memory, loads the address of the first one into the current-descriptor pointer, and sets the run bit. The engine then walks the chain over a 32-bit memory master port. It gathers the buffer of each descriptor into an internal packet store, in list order. It hands each descriptor back to software by clearing its ownership flag in memory. When the chain is finished, it streams the whole packet out as bytes.

A packet is released to the byte stream only after the whole chain has been fetched. A chain that runs out early, or that grows past the packet store, is therefore dropped without a partial frame. In both cases the first descriptor is still handed back to software, the end-of-queue cause is raised and the run bit drops. Two sticky cause bits report "packet sent" and "queue ended". Software clears them by writing 1, and the masked OR of the cause bits drives a registered interrupt line.

Top module: `txchain_dma`

## Requirements
- R1: Descriptor word layout at byte offsets from its base. Offset 0 holds the byte count in bits 31:16. Offset 4 holds the control word, with OWN in bit 31, FIRST in bit 17 and LAST in bit 16. Offset 8 holds the next-descriptor pointer, and offset 12 holds the buffer pointer. Buffer data is read as 32-bit words from the word-aligned buffer address (bits 1:0 ignored), with the lowest-addressed byte in bits 7:0.
- R2: The bytes of all descriptors in a chain are streamed as one packet in list order. The stream starts only after the chain is complete, `pkt_valid` is high on consecutive cycles, and `pkt_last` marks the final byte.
- R3: While the current pointer is zero, the engine makes no memory access, even with the run bit set.
- R4: If the first descriptor of a walk has OWN clear, nothing is written to memory and no packet, cause or pointer change results.
- R5: After its data has been fetched, every descriptor with FIRST clear has its control word rewritten at offset 4 with OWN cleared and all other bits kept.
- R6: Every walk that passes the OWN check ends by rewriting the first descriptor's control word with OWN cleared, whether the packet was sent or aborted.
- R7: At the end of a walk, the current pointer is loaded with the last next-pointer the engine read.
- R8: The packet-sent cause (bit 0) is set only when the total byte count is nonzero and the walk was not aborted.
- R9: A zero next-pointer on a descriptor without LAST aborts the walk, and no byte of that packet is streamed.
- R10: When a walk aborts, or when the new current pointer is zero, the queue-end cause (bit 1) is set and the run bit is cleared in the same cycle.
- R11: A descriptor whose byte count would raise the packet total above `MAX_PKT` aborts the walk. Its data is not fetched, and it is treated as in R9 and R10.
- R12: `irq` is the registered OR of cause AND mask. Writing 1 to a `cause_clr` bit clears that cause unless an event sets it in the same cycle.
- R13: Once raised, `mem_req` stays high with stable address, direction and write data until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the run bit |
| cmd_wdata | input | 1 | New run bit value |
| tx_go | output | 1 | Run bit |
| ptr_we | input | 1 | Write strobe for the current-descriptor pointer |
| ptr_wdata | input | 32 | New current-descriptor pointer |
| cur_ptr | output | 32 | Current-descriptor pointer |
| mask_we | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 2 | New interrupt mask |
| cause_clr | input | 2 | Write-1-to-clear strobes for the cause bits |
| cause | output | 2 | Cause bits: bit 0 packet sent, bit 1 queue ended |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory direction, 1 for write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Final byte of the packet |

## Verification
The engine is driven with five chain patterns, each aimed at a different failure:
- A single complete descriptor whose successor is not owned separates a normal send from the idle poll.
- A three-descriptor chain with a zero-length middle entry and a buffer that crosses a word boundary exposes ordering and byte-lane mistakes.
- A chain that ends early with a null next pointer must not leak any bytes.
- A two-descriptor chain that overflows the packet store takes the abort path while its next pointer is nonzero.
- A lone descriptor with a zero byte count tests the sent-cause condition.

Separate cases load a zero pointer with the run bit set and probe the masked interrupt and the write-1-to-clear behaviour. Each stream byte is matched against a bench-side queue, and `irq` is compared on every clock with a mask-and-cause model.

// File: rtl/txchain_pkg.sv
package txchain_pkg;
  localparam int WORD_W    = 32;
  localparam int BC_SHIFT  = 16;
  localparam int BC_W      = 16;
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 17;
  localparam int LAST_BIT  = 16;
  localparam int CAUSE_W   = 2;
  localparam int CAUSE_BUF = 0;
  localparam int CAUSE_END = 1;
  localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;
  localparam logic [WORD_W-1:0] OFS_CTRL = WORD_W'(4);
  localparam logic [WORD_W-1:0] OFS_NEXT = WORD_W'(8);
  localparam logic [WORD_W-1:0] OFS_BUF  = WORD_W'(12);

  typedef enum logic [3:0] {
    ST_IDLE, ST_D0, ST_D1, ST_D2, ST_D3, ST_CHK, ST_DATA, ST_BYTES,
    ST_POST, ST_WB, ST_NEXT, ST_REL, ST_SEND, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/txchain_ctrl.sv
module txchain_ctrl
  import txchain_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_we,
  input  logic               cmd_wdata,
  input  logic               mask_we,
  input  logic [CAUSE_W-1:0] mask_wdata,
  input  logic [CAUSE_W-1:0] cause_clr,
  input  logic               evt_buf,
  input  logic               evt_end,
  output logic               go,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq
);
  logic [CAUSE_W-1:0] mask_q;
  logic [CAUSE_W-1:0] evt_vec;

  always_comb begin
    evt_vec = '0;
    evt_vec[CAUSE_BUF] = evt_buf;
    evt_vec[CAUSE_END] = evt_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go     <= 1'b0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (evt_end)      go <= 1'b0;
      else if (cmd_we)  go <= cmd_wdata;
      if (mask_we) mask_q <= mask_wdata;
      irq <= |(cause & mask_q);
    end
  end

  for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (rst)             cause[i] <= 1'b0;
      else if (evt_vec[i]) cause[i] <= 1'b1;
      else if (cause_clr[i]) cause[i] <= 1'b0;
    end
  end

  p_end_clears_go_r10: assert property (@(posedge clk) disable iff (rst)
    evt_end |=> (!go && cause[CAUSE_END]));
  p_w1c_buf_r12: assert property (@(posedge clk) disable iff (rst)
    (cause_clr[CAUSE_BUF] && !evt_buf) |=> !cause[CAUSE_BUF]);
endmodule

// File: rtl/txchain_pktbuf.sv
module txchain_pktbuf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_last,
  output logic          pkt_valid,
  output logic [7:0]    pkt_data,
  output logic          pkt_last
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (rd_en) pkt_data <= store[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid <= 1'b0;
      pkt_last  <= 1'b0;
    end else begin
      pkt_valid <= rd_en;
      pkt_last  <= rd_en && rd_last;
    end
  end

  p_last_closes_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(pkt_valid) |-> $past(pkt_last));
endmodule

// File: rtl/txchain_walker.sv
module txchain_walker
  import txchain_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int BAW     = $clog2(MAX_PKT),
  parameter int LEN_W   = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              ptr_we,
  input  logic [WORD_W-1:0] ptr_wdata,
  output logic [WORD_W-1:0] cur_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              bw_en,
  output logic [BAW-1:0]    bw_addr,
  output logic [7:0]        bw_data,
  output logic              rd_en,
  output logic [BAW-1:0]    rd_addr,
  output logic              rd_last,
  output logic              evt_buf,
  output logic              evt_end
);
  localparam int SUM_W = BC_W + 1;

  walk_st_e          st;
  logic [WORD_W-1:0] desc_addr, first_addr, first_cmd, w_cmd, w_next, last_next;
  logic [WORD_W-3:0] w_buf_w, word_ptr;
  logic [BC_W-1:0]   w_bc, bc_left;
  logic [LEN_W-1:0]  tot, send_idx;
  logic [WORD_W-1:0] word_q;
  logic [1:0]        byte_idx;
  logic              walk_first, aborted;
  logic [SUM_W-1:0]  sum_len;

  assign sum_len = SUM_W'(tot) + SUM_W'(w_bc);

  assign bw_en   = (st == ST_BYTES);
  assign bw_addr = tot[BAW-1:0];
  assign bw_data = word_q[8*byte_idx +: 8];
  assign rd_en   = (st == ST_SEND);
  assign rd_addr = send_idx[BAW-1:0];
  assign rd_last = (send_idx == tot - LEN_W'(1));
  assign evt_buf = (st == ST_DONE) && !aborted && (tot != '0);
  assign evt_end = (st == ST_DONE) && (aborted || (last_next == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur_ptr    <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      desc_addr  <= '0;
      first_addr <= '0;
      first_cmd  <= '0;
      w_cmd      <= '0;
      w_next     <= '0;
      w_buf_w    <= '0;
      word_ptr   <= '0;
      w_bc       <= '0;
      bc_left    <= '0;
      tot        <= '0;
      send_idx   <= '0;
      word_q     <= '0;
      byte_idx   <= '0;
      last_next  <= '0;
      walk_first <= 1'b0;
      aborted    <= 1'b0;
    end else begin
      if (ptr_we) cur_ptr <= ptr_wdata;
      case (st)
        ST_IDLE: begin
          if (go && (cur_ptr != '0)) begin
            desc_addr  <= cur_ptr;
            first_addr <= cur_ptr;
            walk_first <= 1'b1;
            aborted    <= 1'b0;
            tot        <= '0;
            st         <= ST_D0;
          end
        end
        ST_D0: begin
          if (!mem_req) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= desc_addr;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            w_bc    <= mem_rdata[BC_SHIFT +: BC_W];
            st      <= ST_D1;
          end
        end
        ST_D1: begin
          if (!mem_req) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= desc_addr + OFS_CTRL;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            w_cmd   <= mem_rdata;
            if (walk_first) first_cmd <= mem_rdata;
            st      <= ST_D2;
          end
        end
        ST_D2: begin
          if (!mem_req) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= desc_addr + OFS_NEXT;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            w_next  <= mem_rdata;
            st      <= ST_D3;
          end
        end
        ST_D3: begin
          if (!mem_req) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= desc_addr + OFS_BUF;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            w_buf_w <= mem_rdata[WORD_W-1:2];
            st      <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (walk_first && !w_cmd[OWN_BIT]) begin
            st <= ST_IDLE;
          end else if (sum_len > SUM_W'(MAX_PKT)) begin
            aborted   <= 1'b1;
            last_next <= w_next;
            st        <= ST_REL;
          end else begin
            walk_first <= 1'b0;
            bc_left    <= w_bc;
            word_ptr   <= w_buf_w;
            st         <= (w_bc == '0) ? ST_POST : ST_DATA;
          end
        end
        ST_DATA: begin
          if (!mem_req) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= {word_ptr, 2'b00};
          end else if (mem_ack) begin
            mem_req  <= 1'b0;
            word_q   <= mem_rdata;
            byte_idx <= 2'd0;
            word_ptr <= word_ptr + 1'b1;
            st       <= ST_BYTES;
          end
        end
        ST_BYTES: begin
          tot      <= tot + LEN_W'(1);
          bc_left  <= bc_left - BC_W'(1);
          byte_idx <= byte_idx + 2'd1;
          if (bc_left == BC_W'(1))  st <= ST_POST;
          else if (byte_idx == 2'd3) st <= ST_DATA;
        end
        ST_POST: begin
          last_next <= w_next;
          st        <= w_cmd[FIRST_BIT] ? ST_NEXT : ST_WB;
        end
        ST_WB: begin
          if (!mem_req) begin
            mem_req   <= 1'b1; mem_we <= 1'b1;
            mem_addr  <= desc_addr + OFS_CTRL;
            mem_wdata <= w_cmd & ~OWN_MASK;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            st      <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (w_cmd[LAST_BIT]) begin
            st <= ST_REL;
          end else if (w_next == '0) begin
            aborted <= 1'b1;
            st      <= ST_REL;
          end else begin
            desc_addr <= w_next;
            st        <= ST_D0;
          end
        end
        ST_REL: begin
          if (!mem_req) begin
            mem_req   <= 1'b1; mem_we <= 1'b1;
            mem_addr  <= first_addr + OFS_CTRL;
            mem_wdata <= first_cmd & ~OWN_MASK;
          end else if (mem_ack) begin
            mem_req  <= 1'b0;
            send_idx <= '0;
            st       <= (!aborted && (tot != '0)) ? ST_SEND : ST_DONE;
          end
        end
        ST_SEND: begin
          send_idx <= send_idx + LEN_W'(1);
          if (rd_last) st <= ST_DONE;
        end
        ST_DONE: begin
          cur_ptr <= last_next;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  p_zero_ptr_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && cur_ptr == '0 && !ptr_we) |=> !mem_req);
  p_no_send_on_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEND) |-> !aborted);
endmodule

// File: rtl/txchain_dma.sv
module txchain_dma
  import txchain_pkg::*;
#(
  parameter int MAX_PKT = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_we,
  input  logic               cmd_wdata,
  output logic               tx_go,
  input  logic               ptr_we,
  input  logic [31:0]        ptr_wdata,
  output logic [31:0]        cur_ptr,
  input  logic               mask_we,
  input  logic [1:0]         mask_wdata,
  input  logic [1:0]         cause_clr,
  output logic [1:0]         cause,
  output logic               irq,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic               pkt_valid,
  output logic [7:0]         pkt_data,
  output logic               pkt_last
);
  localparam int BAW   = $clog2(MAX_PKT);
  localparam int LEN_W = $clog2(MAX_PKT + 1);

  logic           bw_en, rd_en, rd_last, evt_buf, evt_end;
  logic [BAW-1:0] bw_addr, rd_addr;
  logic [7:0]     bw_data;

  txchain_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cause_clr(cause_clr),
    .evt_buf(evt_buf), .evt_end(evt_end),
    .go(tx_go), .cause(cause), .irq(irq)
  );

  txchain_walker #(.MAX_PKT(MAX_PKT), .BAW(BAW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .go(tx_go),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .cur_ptr(cur_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_last(rd_last),
    .evt_buf(evt_buf), .evt_end(evt_end)
  );

  txchain_pktbuf #(.DEPTH(MAX_PKT), .AW(BAW)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(bw_en), .wr_addr(bw_addr), .wr_data(bw_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_last(rd_last),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last)
  );
endmodule

// File: tb/txchain_dma_tb_top.sv
module txchain_dma_tb_top;
  localparam logic [31:0] F_OWN   = 32'h8000_0000;
  localparam logic [31:0] F_FIRST = 32'h0002_0000;
  localparam logic [31:0] F_LAST  = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 0, cmd_wdata = 0, ptr_we = 0, mask_we = 0, mem_ack = 0;
  logic [31:0] ptr_wdata = '0, mem_rdata = '0;
  logic [1:0]  mask_wdata = '0, cause_clr = '0;
  logic tx_go, irq, mem_req, mem_we, pkt_valid, pkt_last;
  logic [31:0] cur_ptr, mem_addr, mem_wdata;
  logic [1:0]  cause;
  logic [7:0]  pkt_data;

  int n_chk = 0, n_fail = 0, acc_cnt = 0, byte_cnt = 0;
  logic [31:0] mem [256];
  logic [7:0]  exp_q [$];
  logic [1:0]  cause_prev = '0, mask_shadow = '0;

  always #10 clk = ~clk;

  txchain_dma dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle ack after a request is seen
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && !rst) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[9:2]];
      mem_ack <= 1'b1;
    end
  end

  // per-clock reference for stream and interrupt
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk(irq == |(cause_prev & mask_shadow), "R12 irq", {31'd0, irq},
          {31'd0, |(cause_prev & mask_shadow)});
      if (pkt_valid) begin
        byte_cnt++;
        if (exp_q.size() == 0) chk(0, "R2 unexpected byte", {24'd0, pkt_data}, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(pkt_data == e, "R2 byte", {24'd0, pkt_data}, {24'd0, e});
          chk(pkt_last == (exp_q.size() == 0), "R2 last", {31'd0, pkt_last},
              {31'd0, exp_q.size() == 0});
        end
      end
      if (mask_we) mask_shadow = mask_wdata;
      cause_prev = cause;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input logic [31:0] a, input int bc, input logic [31:0] ctl,
                          input logic [31:0] nxt, input logic [31:0] buf_a);
    mem[a[9:2]]       = 32'(bc) << 16;
    mem[a[9:2] + 8'd1] = ctl;
    mem[a[9:2] + 8'd2] = nxt;
    mem[a[9:2] + 8'd3] = buf_a;
  endtask

  task automatic put_bytes(input logic [31:0] a, input int n, input logic [7:0] seed,
                           input bit expect_it);
    for (int i = 0; i < n; i++) begin
      logic [31:0] ba;
      ba = a + 32'(i);
      mem[ba[9:2]][8*ba[1:0] +: 8] = seed + 8'(i);
      if (expect_it) exp_q.push_back(seed + 8'(i));
    end
  endtask

  task automatic start(input logic [31:0] p);
    @(negedge clk); ptr_we = 1; ptr_wdata = p;
    @(negedge clk); ptr_we = 0; cmd_we = 1; cmd_wdata = 1;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic wait_go_low();
    for (int i = 0; i < 2000 && tx_go; i++) @(negedge clk);
    chk(!tx_go, "R10 run bit clears", {31'd0, tx_go}, 0);
    cyc(2);
  endtask

  task automatic clear_all();
    @(negedge clk); cause_clr = 2'b11;
    @(negedge clk); cause_clr = 2'b00;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    cyc(4);
    rst = 0;
    cyc(1);
    // reset state
    chk(tx_go == 0 && cause == 0 && irq == 0, "reset ctrl", {29'd0, tx_go, cause}, 0);
    chk(cur_ptr == 0 && !mem_req && !pkt_valid, "reset walk", cur_ptr, 0);

    // R3: zero pointer, run bit set
    begin
      int a0;
      start(32'h0);
      a0 = acc_cnt;
      cyc(30);
      chk(acc_cnt == a0, "R3 no access", 32'(acc_cnt), 32'(a0));
      chk(tx_go == 1, "R3 run bit kept", {31'd0, tx_go}, 1);
      @(negedge clk); cmd_we = 1; cmd_wdata = 0;
      @(negedge clk); cmd_we = 0;
    end

    // single descriptor, successor not owned (R1 R2 R5 R7 R8, then R4)
    put_desc(32'h040, 5, F_OWN | F_FIRST | F_LAST | 32'h55, 32'h080, 32'h200);
    put_desc(32'h080, 3, F_FIRST | F_LAST, 32'h0, 32'h204);
    put_bytes(32'h200, 5, 8'h10, 1);
    start(32'h040);
    for (int i = 0; i < 2000 && !cause[0]; i++) @(negedge clk);
    chk(cause == 2'b01, "R8 sent cause", {30'd0, cause}, 1);
    chk(mem[8'h11] == (F_FIRST | F_LAST | 32'h55), "R6 first released", mem[8'h11],
        F_FIRST | F_LAST | 32'h55);
    chk(cur_ptr == 32'h080, "R7 pointer", cur_ptr, 32'h080);
    chk(exp_q.size() == 0, "R2 all bytes", 32'(exp_q.size()), 0);
    cyc(60);
    chk(mem[8'h21] == (F_FIRST | F_LAST), "R4 unowned untouched", mem[8'h21], F_FIRST | F_LAST);
    chk(cur_ptr == 32'h080 && cause == 2'b01, "R4 no change", cur_ptr, 32'h080);
    @(negedge clk); cmd_we = 1; cmd_wdata = 0;
    @(negedge clk); cmd_we = 0;
    cyc(20);
    clear_all();
    chk(cause == 2'b00, "R12 w1c", {30'd0, cause}, 0);

    // three-descriptor chain with zero-length middle (R1 R2 R5 R10 R12)
    @(negedge clk); mask_we = 1; mask_wdata = 2'b10;
    @(negedge clk); mask_we = 0;
    put_desc(32'h100, 3, F_OWN | F_FIRST, 32'h120, 32'h210);
    put_desc(32'h120, 0, F_OWN | 32'h7, 32'h140, 32'h0);
    put_desc(32'h140, 6, F_OWN | F_LAST | 32'h9, 32'h0, 32'h230);
    put_bytes(32'h210, 3, 8'hA0, 1);
    put_bytes(32'h230, 6, 8'hC0, 1);
    start(32'h100);
    wait_go_low();
    chk(cause == 2'b11, "R8 R10 causes", {30'd0, cause}, 3);
    chk(mem[8'h49] == 32'h7, "R5 middle released", mem[8'h49], 32'h7);
    chk(mem[8'h51] == (F_LAST | 32'h9), "R5 last released", mem[8'h51], F_LAST | 32'h9);
    chk(mem[8'h41] == F_FIRST, "R6 first released", mem[8'h41], F_FIRST);
    chk(cur_ptr == 0, "R7 pointer zero", cur_ptr, 0);
    chk(irq == 1, "R12 masked irq", {31'd0, irq}, 1);
    chk(exp_q.size() == 0, "R2 chain bytes", 32'(exp_q.size()), 0);
    clear_all();

    // null next before LAST: abort (R9 R6 R10)
    begin
      int b0;
      b0 = byte_cnt;
      put_desc(32'h180, 4, F_OWN | F_FIRST, 32'h0, 32'h240);
      put_bytes(32'h240, 4, 8'h33, 0);
      start(32'h180);
      wait_go_low();
      chk(byte_cnt == b0, "R9 no bytes", 32'(byte_cnt), 32'(b0));
      chk(cause == 2'b10, "R9 end only", {30'd0, cause}, 2);
      chk(mem[8'h61] == F_FIRST, "R6 released on abort", mem[8'h61], F_FIRST);
      clear_all();
    end

    // oversize: 40 + 40 > 64 (R11)
    begin
      int b0;
      b0 = byte_cnt;
      put_desc(32'h1C0, 40, F_OWN | F_FIRST, 32'h1E0, 32'h280);
      put_desc(32'h1E0, 40, F_OWN | F_LAST, 32'h300, 32'h2C0);
      start(32'h1C0);
      wait_go_low();
      chk(byte_cnt == b0, "R11 no bytes", 32'(byte_cnt), 32'(b0));
      chk(cause == 2'b10, "R11 end cause", {30'd0, cause}, 2);
      chk(cur_ptr == 32'h300, "R11 R7 pointer", cur_ptr, 32'h300);
      chk(mem[8'h79] == (F_OWN | F_LAST), "R11 offender kept", mem[8'h79], F_OWN | F_LAST);
      chk(mem[8'h71] == F_FIRST, "R11 first released", mem[8'h71], F_FIRST);
      clear_all();
    end

    // zero total length with LAST (R8)
    put_desc(32'h340, 0, F_OWN | F_FIRST | F_LAST, 32'h0, 32'h0);
    start(32'h340);
    wait_go_low();
    chk(cause == 2'b10, "R8 no sent cause on zero length", {30'd0, cause}, 2);
    chk(mem[8'hD1] == (F_FIRST | F_LAST), "R6 zero-length release", mem[8'hD1], F_FIRST | F_LAST);

    cyc(5);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule